// File: doc/BRIEF.md
# Shared Interrupt Sense, Mask and Core Router

This block collects a bank of shared interrupt inputs, already synchronous to its clock, and turns each one into a pending bit. Each source has its own sense settings. A polarity bit selects active-high or active-low. A trigger bit selects level or edge. A dual-edge bit makes an edge-mode source latch on any transition. Edge-latched sources stay pending until software acknowledges them through a single edge-command register. The same register can also raise an edge-pending bit directly, which lets one core signal another.

A per-source mask enable is changed through two write-one ports: one sets bits, the other clears them. Each source carries a route word that names exactly one target core and a valid flag. Every core receives one registered interrupt line. That line is the OR of all sources that are pending, unmasked, validly routed and aimed at that core. Software accesses the block through a simple synchronous register port. Writes take effect at the clock edge. Read data is registered and appears one cycle after the read strobe.

Top module: `sirq_router`

## Requirements
- R1: After reset, every core line is low, all mask bits are 0 (masked), all polarity, trigger and dual-edge bits are 0 (active-high, level, single-edge), and every route word reads 0 (not valid, core 0).
- R2: Writing word address 0x030+w sets mask bits, and writing 0x038+w clears them, only where the written data bit is 1. Zero bits leave their sources unchanged. The mask bank reads back at 0x028+w, where word w covers sources 32w..32w+31.
- R3: The polarity bank (bit 1 = active-low) sits at 0x010+w, the trigger bank (bit 1 = edge) at 0x018+w and the dual-edge bank (bit 1 = both transitions) at 0x020+w. Each is a read/write word of 32 sources.
- R4: In level mode a source is pending exactly while its input XOR its polarity bit is 1, so it follows the input.
- R5: In edge mode with dual-edge off, a low-to-high transition of the polarity-corrected input latches the source pending. With polarity 0 this is a rising input; with polarity 1 it is a falling input. The opposite transition does not latch. A latched bit stays set after the input returns.
- R6: In edge mode with dual-edge on, both rising and falling input transitions latch the source pending, whatever its polarity bit is.
- R7: The edge-command word at 0x001 takes a source number in bits [7:0] and an action in bit 31 (1 = set, 0 = clear). Set latches an edge-mode source pending. Clear acknowledges it. Neither action has any effect on a level-mode source. A command naming a source number at or above the source count is ignored.
- R8: The route word of source s is at 0x100+s, with bit 31 = valid and bits [CORE_W-1:0] = target core. A source drives only the line of the core it names, and drives no line while its route is not valid or its mask bit is 0.
- R9: Each core line is the OR of all qualifying sources aimed at it. The line is registered, so it changes on the first clock edge after the pending, mask or route change that causes it.
- R10: The pending vector reads at 0x040+w.
- R11: Word 0x000 reads as a configuration word: bits [7:0] = NUM_SRC/8-1 and bits [19:16] = NUM_CORE-1. Read data appears one cycle after reg_re and holds while reg_re is low. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Shared interrupt inputs, synchronous to clk |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 10 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| core_irq_o | output | NUM_CORE | Per-core interrupt lines |

## Verification
Level sources are driven steady high and low, with the polarity flipped under a steady input. This separates polarity inversion from the pin value itself. Edge sources are given single rising and single falling pulses under both polarities. Each pulse is held and then released, which shows latching apart from level following. Dual-edge sources see both directions while their polarity is set to active-low. The edge-command register is aimed at edge sources, at level sources and at an out-of-range number whose low bits alias a live edge source. Routing is moved between cores and invalidated, and two sources are placed on one core and then on different cores, to check the OR and the exclusivity of each route.

// File: rtl/sirq_pkg.sv
`timescale 1ns/1ps
package sirq_pkg;
  localparam int ADDR_W = 10;
  localparam int WORD_W = 32;

  localparam logic [ADDR_W-1:0] OFS_CONFIG = 10'h000;
  localparam logic [ADDR_W-1:0] OFS_EDGE   = 10'h001;
  localparam logic [ADDR_W-1:0] OFS_POL    = 10'h010;
  localparam logic [ADDR_W-1:0] OFS_TRIG   = 10'h018;
  localparam logic [ADDR_W-1:0] OFS_DUAL   = 10'h020;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 10'h028;
  localparam logic [ADDR_W-1:0] OFS_SMASK  = 10'h030;
  localparam logic [ADDR_W-1:0] OFS_RMASK  = 10'h038;
  localparam logic [ADDR_W-1:0] OFS_PEND   = 10'h040;
  localparam logic [ADDR_W-1:0] OFS_ROUTE  = 10'h100;

  function automatic logic [ADDR_W-1:0] word_addr(input logic [ADDR_W-1:0] base,
                                                  input int idx);
    return base + ADDR_W'(idx);
  endfunction

  function automatic logic [WORD_W-1:0] cfg_word(input int nsrc, input int ncore);
    return {12'd0, 4'(ncore - 1), 8'd0, 8'(nsrc / 8 - 1)};
  endfunction
endpackage

// File: rtl/sirq_regfile.sv
`timescale 1ns/1ps
module sirq_regfile import sirq_pkg::*; #(
  parameter int NUM_SRC  = 64,
  parameter int NUM_CORE = 4,
  localparam int CORE_W  = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1,
  localparam int NWORD   = NUM_SRC / WORD_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [WORD_W-1:0]              wdata,
  output logic [NUM_SRC-1:0]             pol_o,
  output logic [NUM_SRC-1:0]             trig_o,
  output logic [NUM_SRC-1:0]             dual_o,
  output logic [NUM_SRC-1:0]             mask_o,
  output logic [NUM_SRC-1:0]             rvld_o,
  output logic [NUM_SRC-1:0][CORE_W-1:0] rcore_o,
  output logic [NUM_SRC-1:0]             eset_o,
  output logic [NUM_SRC-1:0]             eclr_o
);
  logic [NUM_SRC-1:0]             pol_q, pol_d, trig_q, trig_d, dual_q, dual_d;
  logic [NUM_SRC-1:0]             mask_q, mask_d, rvld_q, rvld_d;
  logic [NUM_SRC-1:0][CORE_W-1:0] rcore_q, rcore_d;

  // next-state: bank writes, write-one mask ports, route words, edge command
  always_comb begin
    pol_d   = pol_q;
    trig_d  = trig_q;
    dual_d  = dual_q;
    mask_d  = mask_q;
    rvld_d  = rvld_q;
    rcore_d = rcore_q;
    eset_o  = '0;
    eclr_o  = '0;
    if (we) begin
      for (int w = 0; w < NWORD; w++) begin
        if (addr == word_addr(OFS_POL, w))   pol_d[w*WORD_W +: WORD_W]  = wdata;
        if (addr == word_addr(OFS_TRIG, w))  trig_d[w*WORD_W +: WORD_W] = wdata;
        if (addr == word_addr(OFS_DUAL, w))  dual_d[w*WORD_W +: WORD_W] = wdata;
        if (addr == word_addr(OFS_SMASK, w))
          mask_d[w*WORD_W +: WORD_W] = mask_q[w*WORD_W +: WORD_W] | wdata;
        if (addr == word_addr(OFS_RMASK, w))
          mask_d[w*WORD_W +: WORD_W] = mask_q[w*WORD_W +: WORD_W] & ~wdata;
      end
      for (int s = 0; s < NUM_SRC; s++) begin
        if (addr == word_addr(OFS_ROUTE, s)) begin
          rvld_d[s]  = wdata[WORD_W-1];
          rcore_d[s] = wdata[CORE_W-1:0];
        end
        if (addr == OFS_EDGE && wdata[7:0] == 8'(s)) begin
          eset_o[s] = wdata[WORD_W-1];
          eclr_o[s] = ~wdata[WORD_W-1];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q   <= '0;
      trig_q  <= '0;
      dual_q  <= '0;
      mask_q  <= '0;
      rvld_q  <= '0;
      rcore_q <= '0;
    end else if (we) begin
      pol_q   <= pol_d;
      trig_q  <= trig_d;
      dual_q  <= dual_d;
      mask_q  <= mask_d;
      rvld_q  <= rvld_d;
      rcore_q <= rcore_d;
    end
  end

  assign pol_o   = pol_q;
  assign trig_o  = trig_q;
  assign dual_o  = dual_q;
  assign mask_o  = mask_q;
  assign rvld_o  = rvld_q;
  assign rcore_o = rcore_q;
endmodule

// File: rtl/sirq_sense.sv
`timescale 1ns/1ps
module sirq_sense #(
  parameter int NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] pol_i,
  input  logic [NUM_SRC-1:0] trig_i,
  input  logic [NUM_SRC-1:0] dual_i,
  input  logic [NUM_SRC-1:0] eset_i,
  input  logic [NUM_SRC-1:0] eclr_i,
  output logic [NUM_SRC-1:0] pend_o
);
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic prev_q, edge_q, edge_d;
    logic active, prev_active, hit;

    always_comb begin
      active      = src_i[s] ^ pol_i[s];
      prev_active = prev_q ^ pol_i[s];
      hit         = dual_i[s] ? (src_i[s] ^ prev_q) : (active & ~prev_active);
      // a new transition wins over a same-cycle acknowledge
      edge_d      = trig_i[s] & ((edge_q & ~eclr_i[s]) | hit | eset_i[s]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= 1'b0;
        edge_q <= 1'b0;
      end else begin
        prev_q <= src_i[s];
        edge_q <= edge_d;
      end
    end

    assign pend_o[s] = trig_i[s] ? edge_q : active;
  end
endmodule

// File: rtl/sirq_route.sv
`timescale 1ns/1ps
module sirq_route #(
  parameter int NUM_SRC  = 64,
  parameter int NUM_CORE = 4,
  localparam int CORE_W  = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_SRC-1:0]             pend_i,
  input  logic [NUM_SRC-1:0]             mask_i,
  input  logic [NUM_SRC-1:0]             rvld_i,
  input  logic [NUM_SRC-1:0][CORE_W-1:0] rcore_i,
  output logic [NUM_CORE-1:0]            irq_o
);
  logic [NUM_CORE-1:0] irq_d, irq_q;
  logic [NUM_SRC-1:0]  live;

  assign live = pend_i & mask_i & rvld_i;

  for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
    logic [NUM_SRC-1:0] aimed;
    always_comb begin
      for (int s = 0; s < NUM_SRC; s++)
        aimed[s] = (rcore_i[s] == CORE_W'(c));
    end
    assign irq_d[c] = |(live & aimed);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/sirq_router.sv
`timescale 1ns/1ps
module sirq_router import sirq_pkg::*; #(
  parameter int NUM_SRC  = 64,
  parameter int NUM_CORE = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  src_i,
  input  logic                reg_we,
  input  logic                reg_re,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [WORD_W-1:0]   reg_wdata,
  output logic [WORD_W-1:0]   reg_rdata,
  output logic [NUM_CORE-1:0] core_irq_o
);
  localparam int CORE_W = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1;
  localparam int NWORD  = NUM_SRC / WORD_W;
  localparam logic [WORD_W-1:0] CFG = cfg_word(NUM_SRC, NUM_CORE);

  logic [NUM_SRC-1:0]             pol, trig, dual, mask, rvld, eset, eclr, pend;
  logic [NUM_SRC-1:0][CORE_W-1:0] rcore;
  logic [WORD_W-1:0]              rdata_d, rdata_q;

  sirq_regfile #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .pol_o(pol), .trig_o(trig), .dual_o(dual), .mask_o(mask),
    .rvld_o(rvld), .rcore_o(rcore), .eset_o(eset), .eclr_o(eclr)
  );

  sirq_sense #(.NUM_SRC(NUM_SRC)) u_sense (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .pol_i(pol), .trig_i(trig),
    .dual_i(dual), .eset_i(eset), .eclr_i(eclr), .pend_o(pend)
  );

  sirq_route #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE)) u_route (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .mask_i(mask), .rvld_i(rvld),
    .rcore_i(rcore), .irq_o(core_irq_o)
  );

  // read mux
  always_comb begin
    rdata_d = '0;
    if (reg_addr == OFS_CONFIG) rdata_d = CFG;
    for (int w = 0; w < NWORD; w++) begin
      if (reg_addr == word_addr(OFS_POL, w))  rdata_d = pol[w*WORD_W +: WORD_W];
      if (reg_addr == word_addr(OFS_TRIG, w)) rdata_d = trig[w*WORD_W +: WORD_W];
      if (reg_addr == word_addr(OFS_DUAL, w)) rdata_d = dual[w*WORD_W +: WORD_W];
      if (reg_addr == word_addr(OFS_MASK, w)) rdata_d = mask[w*WORD_W +: WORD_W];
      if (reg_addr == word_addr(OFS_PEND, w)) rdata_d = pend[w*WORD_W +: WORD_W];
    end
    for (int s = 0; s < NUM_SRC; s++) begin
      if (reg_addr == word_addr(OFS_ROUTE, s))
        rdata_d = {rvld[s], {(WORD_W-1-CORE_W){1'b0}}, rcore[s]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (reg_re) rdata_q <= rdata_d;
  end

  assign reg_rdata = rdata_q;
endmodule

// File: rtl/sirq_router_chk.sv
`timescale 1ns/1ps
module sirq_router_chk import sirq_pkg::*; #(
  parameter int NUM_SRC  = 64,
  parameter int NUM_CORE = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                src0,
  input logic                reg_we,
  input logic                reg_re,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic [7:0]          wd_lo,
  input logic                wd_top,
  input logic [WORD_W-1:0]   reg_rdata,
  input logic [NUM_CORE-1:0] core_irq,
  input logic [NUM_SRC-1:0]  mask,
  input logic                pend0,
  input logic                trig0,
  input logic                dual0
);
  localparam logic [WORD_W-1:0] CFG_EXP = cfg_word(NUM_SRC, NUM_CORE);

  // R2
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == OFS_SMASK && wd_lo[0]) |=> mask[0]);

  // R2
  mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == OFS_RMASK && wd_lo[0]) |=> !mask[0]);

  // R8
  all_masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |=> (core_irq == '0));

  // R6
  dual_edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig0 && dual0 && !reg_we && (src0 != $past(src0))) |=> pend0);

  // R7
  edge_cmd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == OFS_EDGE && wd_top && wd_lo == 8'd0 && trig0) |=> pend0);

  // R11
  config_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_re && reg_addr == OFS_CONFIG) |=> (reg_rdata == CFG_EXP));
endmodule

bind sirq_router sirq_router_chk #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE)) u_chk (
  .clk(clk), .rst_n(rst_n), .src0(src_i[0]), .reg_we(reg_we), .reg_re(reg_re),
  .reg_addr(reg_addr), .wd_lo(reg_wdata[7:0]), .wd_top(reg_wdata[31]),
  .reg_rdata(reg_rdata), .core_irq(core_irq_o), .mask(mask),
  .pend0(pend[0]), .trig0(trig[0]), .dual0(dual[0])
);

// File: tb/sirq_router_test.sv
`timescale 1ns/1ps
module sirq_router_test;
  localparam int NS = 64;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic          reg_we = 1'b0, reg_re = 1'b0;
  logic [9:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NC-1:0] core_irq;
  int            n_chk = 0, n_fail = 0;
  bit            done = 1'b0;

  always #2.5 clk = ~clk;

  sirq_router #(.NUM_SRC(NS), .NUM_CORE(NC)) uut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .core_irq_o(core_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 core lines", 32'(core_irq), 32'h0);
    rd(10'h028, v); check("R1 mask word0", v, 32'h0);
    rd(10'h029, v); check("R1 mask word1", v, 32'h0);
    rd(10'h010, v); check("R1 polarity", v, 32'h0);
    rd(10'h018, v); check("R1 trigger", v, 32'h0);
    rd(10'h103, v); check("R1 route", v, 32'h0);
  endtask

  task automatic t_config();
    logic [31:0] v;
    rd(10'h000, v); check("R11 config word", v, 32'h0003_0007);
    @(negedge clk); reg_addr = 10'h3FF;
    step(1); check("R11 rdata holds", reg_rdata, 32'h0003_0007);
    rd(10'h3FF, v); check("R11 unmapped", v, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] v;
    wr(10'h103, 32'h8000_0001);
    wr(10'h030, 32'h08);
    src[3] = 1'b1;
    check("R9 no change before edge", 32'(core_irq), 32'h0);
    step(1); check("R4 level high", 32'(core_irq), 32'b0010);
    rd(10'h040, v); check("R10 pending word0", v, 32'h08);
    wr(10'h010, 32'h08); step(1);
    check("R4 active-low inverts", 32'(core_irq), 32'h0);
    wr(10'h010, 32'h00); step(1);
    check("R4 active-high again", 32'(core_irq), 32'b0010);
    wr(10'h001, 32'h0000_0003); step(1);
    check("R7 clear on level no effect", 32'(core_irq), 32'b0010);
    rd(10'h040, v); check("R7 level still pending", v, 32'h08);
    wr(10'h103, 32'h8000_0003); step(1);
    check("R8 moved to core3", 32'(core_irq), 32'b1000);
    wr(10'h103, 32'h0000_0003); step(1);
    check("R8 invalid route", 32'(core_irq), 32'h0);
    wr(10'h103, 32'h8000_0001);
    wr(10'h038, 32'h08); step(1);
    check("R2 cleared mask", 32'(core_irq), 32'h0);
    wr(10'h030, 32'h20); rd(10'h028, v); check("R2 set bit5 only", v, 32'h20);
    wr(10'h030, 32'h08); rd(10'h028, v); check("R2 set keeps others", v, 32'h28);
    wr(10'h038, 32'h20); rd(10'h028, v); check("R2 clear keeps others", v, 32'h08);
    check("R8 restored route", 32'(core_irq), 32'b0010);
    src[3] = 1'b0; step(1);
    check("R4 level follows low", 32'(core_irq), 32'h0);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    wr(10'h018, 32'h20);
    wr(10'h105, 32'h8000_0002);
    wr(10'h030, 32'h20);
    src[5] = 1'b1; step(2);
    check("R5 rising latches", 32'(core_irq), 32'b0100);
    src[5] = 1'b0; step(2);
    check("R5 held after release", 32'(core_irq), 32'b0100);
    rd(10'h040, v); check("R10 edge pending", v, 32'h20);
    wr(10'h001, 32'h0000_0005); step(1);
    check("R7 clear acknowledges", 32'(core_irq), 32'h0);
    rd(10'h040, v); check("R7 pending cleared", v, 32'h0);
    wr(10'h010, 32'h20);
    src[5] = 1'b1; step(2);
    check("R5 active-low ignores rise", 32'(core_irq), 32'h0);
    src[5] = 1'b0; step(2);
    check("R5 active-low falls latch", 32'(core_irq), 32'b0100);
    wr(10'h001, 32'h0000_0005);
    wr(10'h010, 32'h00); step(1);
    check("R7 cleared again", 32'(core_irq), 32'h0);
  endtask

  task automatic t_dual();
    logic [31:0] v;
    wr(10'h018, 32'h60);
    wr(10'h020, 32'h40);
    wr(10'h010, 32'h40);
    wr(10'h106, 32'h8000_0000);
    wr(10'h030, 32'h40);
    rd(10'h018, v); check("R3 trigger readback", v, 32'h60);
    rd(10'h020, v); check("R3 dual readback", v, 32'h40);
    rd(10'h010, v); check("R3 polarity readback", v, 32'h40);
    src[6] = 1'b1; step(2);
    check("R6 rise latches", 32'(core_irq), 32'b0001);
    wr(10'h001, 32'h0000_0006); step(1);
    check("R6 cleared", 32'(core_irq), 32'h0);
    src[6] = 1'b0; step(2);
    check("R6 fall latches", 32'(core_irq), 32'b0001);
    wr(10'h001, 32'h0000_0006); step(1);
    check("R6 cleared after fall", 32'(core_irq), 32'h0);
  endtask

  task automatic t_cmd();
    logic [31:0] v;
    wr(10'h018, 32'hE0);
    wr(10'h107, 32'h8000_0003);
    wr(10'h030, 32'h80);
    wr(10'h001, 32'h8000_0007); step(1);
    check("R7 set raises", 32'(core_irq), 32'b1000);
    rd(10'h040, v); check("R7 set pending", v, 32'h80);
    src[3] = 1'b1; step(1);
    check("R9 two cores", 32'(core_irq), 32'b1010);
    wr(10'h103, 32'h8000_0003); step(1);
    check("R9 shared core", 32'(core_irq), 32'b1000);
    wr(10'h001, 32'h0000_0007); step(1);
    check("R9 remaining source", 32'(core_irq), 32'b1000);
    src[3] = 1'b0; step(1);
    check("R9 all low", 32'(core_irq), 32'h0);
    wr(10'h001, 32'h8000_0008);
    rd(10'h040, v); check("R7 set on level ignored", v, 32'h0);
    wr(10'h001, 32'h8000_00C7);
    rd(10'h040, v); check("R7 out-of-range ignored", v, 32'h0);
    check("R7 out-of-range no line", 32'(core_irq), 32'h0);
    src[40] = 1'b1; step(1);
    rd(10'h041, v); check("R10 pending word1", v, 32'h100);
    src[40] = 1'b0;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_config();
    t_level();
    t_edge();
    t_dual();
    t_cmd();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule